// File: doc/BRIEF.md
# Next Program Counter Selector

This block decides where a 32-bit RISC core fetches next. It takes the current program counter, the instruction word, the outcome of a register equality compare, a register-held jump address and a decoded control-flow kind. From these it produces the following fetch address in the same cycle. It is purely combinational, so the core's PC register and the register file are outside it.

Three ways of forming a target live side by side. The first is a PC-relative branch, where a signed word offset is added to the incremented PC. The second is a pseudodirect jump, where a 26-bit word address is placed under the top bits of the incremented PC. The third is an indirect jump, where the address is taken as-is from a register. For the call-style jump, the block also raises a write strobe toward the return-address register and supplies the value to store there.

Top module: `next_pc_unit`

## Requirements
- R1: With kind code 0 (sequential), next_pc_o equals pc_i + 4, modulo 2^32.
- R2: With kind code 1 (branch if equal) and regs_equal_i high, next_pc_o equals pc_i + 4 + (instr_i[15:0] sign-extended, times 4).
- R3: With kind code 1 and regs_equal_i low, next_pc_o equals pc_i + 4.
- R4: With kind code 2 (branch if not equal), the branch is taken to the R2 target when regs_equal_i is low. Otherwise next_pc_o is pc_i + 4.
- R5: An offset field with bit 15 set moves the target backwards. For example, 16'hFFFF gives pc_i + 4 - 4 = pc_i.
- R6: With kind code 3 (jump), next_pc_o is {(pc_i+4)[31:28], instr_i[25:0], 2'b00}.
- R7: With kind code 4 (jump and link), next_pc_o is the R6 target. In addition, link_we_o is 1, link_data_o is pc_i + 4, and link_idx_o is 31.
- R8: With kind code 5 (register jump), next_pc_o equals jr_target_i bit for bit, including its two low bits.
- R9: link_we_o is 0 for every kind code other than 4.
- R10: The unused kind codes 6 and 7 behave as sequential: next_pc_o is pc_i + 4 and link_we_o is 0.
- R11: When pc_i + 4 carries into bit 28, a jump takes its upper four bits from the incremented PC, not from pc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| regs_equal_i | input | 1 | High when the two compared registers hold equal values |
| jr_target_i | input | 32 | Register value used by the register jump |
| kind_i | input | 3 | Decoded control-flow kind (codes listed in R1 to R10) |
| next_pc_o | output | 32 | Address to fetch next |
| link_we_o | output | 1 | Write strobe for the return-address register |
| link_idx_o | output | 5 | Index of the return-address register |
| link_data_o | output | 32 | Return address to write |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit offset that is sign-extended, a 26-bit jump field, word alignment, and upper jump bits taken from the incremented PC. With these values, the addresses where the carry matters are easy to reach. These are the wrap from 0xFFFFFFFC to zero and the carry across bit 28. At those points a design that reads the upper jump bits from the unincremented PC gives a different result. Negative offsets and the two undefined kind codes are also driven, alongside a long run of pseudo-random words over every code.

// File: rtl/npc_pkg.sv
package npc_pkg;

   localparam int unsigned NPC_KIND_W = 3;

   typedef enum logic [NPC_KIND_W-1:0] {
      NPC_SEQ  = 3'd0,
      NPC_BEQ  = 3'd1,
      NPC_BNE  = 3'd2,
      NPC_JMP  = 3'd3,
      NPC_JAL  = 3'd4,
      NPC_JREG = 3'd5
   } npc_kind_e;

endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned ALIGN = 2
) (
   input  logic [XLEN-1:0] pc_i,
   output logic [XLEN-1:0] pc_plus_o
);
   localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN;

   assign pc_plus_o = pc_i + STEP;
endmodule

// File: rtl/npc_branch_tgt.sv
module npc_branch_tgt #(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned OFFS_W      = 16,
   parameter int unsigned ALIGN       = 2,
   parameter bit          SIGNED_OFFS = 1'b1
) (
   input  logic [XLEN-1:0]   pc_plus_i,
   input  logic [OFFS_W-1:0] offs_i,
   output logic [XLEN-1:0]   target_o
);
   localparam int unsigned EXT_W = XLEN - OFFS_W - ALIGN;

   logic             fill;
   logic [XLEN-1:0]  scaled;

   generate
      if (SIGNED_OFFS) begin : g_sext
         assign fill = offs_i[OFFS_W-1];
      end else begin : g_zext
         assign fill = 1'b0;
      end

      if (ALIGN == 0) begin : g_noshift
         assign scaled = {{EXT_W{fill}}, offs_i};
      end else begin : g_shift
         assign scaled = {{EXT_W{fill}}, offs_i, {ALIGN{1'b0}}};
      end
   endgenerate

   assign target_o = pc_plus_i + scaled;
endmodule

// File: rtl/npc_jump_tgt.sv
module npc_jump_tgt #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned TGT_W = 26,
   parameter int unsigned ALIGN = 2
) (
   input  logic [XLEN-TGT_W-ALIGN-1:0] region_i,
   input  logic [TGT_W-1:0]            field_i,
   output logic [XLEN-1:0]             target_o
);
   generate
      if (ALIGN == 0) begin : g_noshift
         assign target_o = {region_i, field_i};
      end else begin : g_shift
         assign target_o = {region_i, field_i, {ALIGN{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
   import npc_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  npc_kind_e       kind_i,
   input  logic            equal_i,
   input  logic [XLEN-1:0] pc_plus_i,
   input  logic [XLEN-1:0] br_tgt_i,
   input  logic [XLEN-1:0] j_tgt_i,
   input  logic [XLEN-1:0] reg_tgt_i,
   output logic [XLEN-1:0] next_o,
   output logic            link_o
);
   always_comb begin
      next_o = pc_plus_i;
      link_o = 1'b0;
      case (kind_i)
         NPC_BEQ:  if (equal_i)  next_o = br_tgt_i;
         NPC_BNE:  if (!equal_i) next_o = br_tgt_i;
         NPC_JMP:  next_o = j_tgt_i;
         NPC_JAL: begin
            next_o = j_tgt_i;
            link_o = 1'b1;
         end
         NPC_JREG: next_o = reg_tgt_i;
         default:  next_o = pc_plus_i;
      endcase
   end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
   import npc_pkg::*;
#(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned INSTR_W      = 32,
   parameter int unsigned OFFS_W       = 16,
   parameter int unsigned TGT_W        = 26,
   parameter int unsigned ALIGN        = 2,
   parameter int unsigned REG_W        = 5,
   parameter int unsigned LINK_REG     = 31,
   parameter bit          SIGNED_OFFS  = 1'b1,
   parameter bit          REGION_PLUS  = 1'b1
) (
   input  logic [XLEN-1:0]       pc_i,
   input  logic [INSTR_W-1:0]    instr_i,
   input  logic                  regs_equal_i,
   input  logic [XLEN-1:0]       jr_target_i,
   input  logic [NPC_KIND_W-1:0] kind_i,
   output logic [XLEN-1:0]       next_pc_o,
   output logic                  link_we_o,
   output logic [REG_W-1:0]      link_idx_o,
   output logic [XLEN-1:0]       link_data_o
);
   localparam int unsigned HI_W = XLEN - TGT_W - ALIGN;

   generate
      if (TGT_W + ALIGN >= XLEN) begin : g_bad_tgt
         $error("jump field plus alignment must leave region bits");
      end
      if (OFFS_W + ALIGN > XLEN) begin : g_bad_offs
         $error("branch offset too wide for address");
      end
      if (TGT_W > INSTR_W || OFFS_W > TGT_W) begin : g_bad_fields
         $error("instruction fields do not fit the word");
      end
      if (LINK_REG >= (1 << REG_W)) begin : g_bad_link
         $error("link register index out of range");
      end
   endgenerate

   npc_kind_e        kind;
   logic [XLEN-1:0]  pc_plus;
   logic [XLEN-1:0]  br_tgt;
   logic [XLEN-1:0]  j_tgt;
   logic [HI_W-1:0]  region;
   logic             unused_opcode;

   assign kind          = npc_kind_e'(kind_i);
   assign unused_opcode = ^instr_i[INSTR_W-1:TGT_W];

   npc_incr #(.XLEN(XLEN), .ALIGN(ALIGN)) u_incr (
      .pc_i      (pc_i),
      .pc_plus_o (pc_plus)
   );

   npc_branch_tgt #(
      .XLEN(XLEN), .OFFS_W(OFFS_W), .ALIGN(ALIGN), .SIGNED_OFFS(SIGNED_OFFS)
   ) u_br (
      .pc_plus_i (pc_plus),
      .offs_i    (instr_i[OFFS_W-1:0]),
      .target_o  (br_tgt)
   );

   generate
      if (REGION_PLUS) begin : g_region_plus
         assign region = pc_plus[XLEN-1 -: HI_W];
      end else begin : g_region_cur
         assign region = pc_i[XLEN-1 -: HI_W];
      end
   endgenerate

   npc_jump_tgt #(.XLEN(XLEN), .TGT_W(TGT_W), .ALIGN(ALIGN)) u_jmp (
      .region_i (region),
      .field_i  (instr_i[TGT_W-1:0]),
      .target_o (j_tgt)
   );

   npc_select #(.XLEN(XLEN)) u_sel (
      .kind_i    (kind),
      .equal_i   (regs_equal_i),
      .pc_plus_i (pc_plus),
      .br_tgt_i  (br_tgt),
      .j_tgt_i   (j_tgt),
      .reg_tgt_i (jr_target_i),
      .next_o    (next_pc_o),
      .link_o    (link_we_o)
   );

   assign link_idx_o  = REG_W'(LINK_REG);
   assign link_data_o = pc_plus;
endmodule

// File: rtl/next_pc_unit_chk.sv
module next_pc_unit_chk #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned TGT_W = 26,
   parameter int unsigned ALIGN = 2
) (
   input logic [XLEN-1:0] pc_i,
   input logic [31:0]     instr_i,
   input logic            regs_equal_i,
   input logic [XLEN-1:0] jr_target_i,
   input logic [2:0]      kind_i,
   input logic [XLEN-1:0] next_pc_o,
   input logic            link_we_o,
   input logic [XLEN-1:0] link_data_o
);
   localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN;

   always_comb begin
      // R1
      seq_step_chk: assert (kind_i != 3'd0 || next_pc_o == pc_i + STEP);
      // R3
      beq_fall_chk: assert (!(kind_i == 3'd1 && !regs_equal_i) || next_pc_o == pc_i + STEP);
      // R4
      bne_fall_chk: assert (!(kind_i == 3'd2 && regs_equal_i) || next_pc_o == pc_i + STEP);
      // R6
      jmp_field_chk: assert (!(kind_i == 3'd3 || kind_i == 3'd4)
                             || next_pc_o[TGT_W+ALIGN-1:ALIGN] == instr_i[TGT_W-1:0]);
      // R7
      jal_link_chk: assert (kind_i != 3'd4 || (link_we_o && link_data_o == pc_i + STEP));
      // R8
      jreg_pass_chk: assert (kind_i != 3'd5 || next_pc_o == jr_target_i);
      // R9
      no_link_chk: assert (kind_i == 3'd4 || !link_we_o);
      // R10
      undef_kind_chk: assert (kind_i < 3'd6 || next_pc_o == pc_i + STEP);
   end
endmodule

bind next_pc_unit next_pc_unit_chk #(.XLEN(XLEN), .TGT_W(TGT_W), .ALIGN(ALIGN)) u_chk (
   .pc_i         (pc_i),
   .instr_i      (instr_i),
   .regs_equal_i (regs_equal_i),
   .jr_target_i  (jr_target_i),
   .kind_i       (kind_i),
   .next_pc_o    (next_pc_o),
   .link_we_o    (link_we_o),
   .link_data_o  (link_data_o)
);

// File: tb/test_next_pc_unit.sv
module test_next_pc_unit;

   typedef struct {
      string       req;
      logic [31:0] nxt;
      logic        we;
      logic [31:0] ldata;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] pc, instr, jrv, nxt, ldata;
   logic        eq, we;
   logic [2:0]  kind;
   logic [4:0]  lidx;
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;
   exp_t        q[$];

   always #10 clk = ~clk;

   next_pc_unit i_next_pc_unit (
      .pc_i(pc), .instr_i(instr), .regs_equal_i(eq), .jr_target_i(jrv),
      .kind_i(kind), .next_pc_o(nxt), .link_we_o(we), .link_idx_o(lidx),
      .link_data_o(ldata)
   );

   function automatic exp_t model(string req, logic [2:0] k, logic [31:0] p,
                                  logic [31:0] w, logic e, logic [31:0] r);
      exp_t        x;
      logic [31:0] p4  = p + 32'd4;
      logic [31:0] brt = p4 + {{14{w[15]}}, w[15:0], 2'b00};
      logic [31:0] jt  = {p4[31:28], w[25:0], 2'b00};
      x.req = req; x.we = 1'b0; x.ldata = p4; x.nxt = p4;
      case (k)
         3'd1: if (e)  x.nxt = brt;
         3'd2: if (!e) x.nxt = brt;
         3'd3: x.nxt = jt;
         3'd4: begin x.nxt = jt; x.we = 1'b1; end
         3'd5: x.nxt = r;
         default: x.nxt = p4;
      endcase
      return x;
   endfunction

   task automatic drive(string req, logic [2:0] k, logic [31:0] p,
                        logic [31:0] w, logic e, logic [31:0] r);
      @(posedge clk);
      kind = k; pc = p; instr = w; eq = e; jrv = r;
      q.push_back(model(req, k, p, w, e, r));
   endtask

   initial begin : monitor
      exp_t x;
      forever begin
         @(negedge clk);
         if (q.size() != 0) begin
            x = q.pop_front();
            n_cmp++;
            if (nxt !== x.nxt) begin
               n_bad++;
               $display("FAIL %s next_pc actual %h expected %h", x.req, nxt, x.nxt);
            end
            if (we !== x.we) begin
               n_bad++;
               $display("FAIL %s link_we actual %b expected %b", x.req, we, x.we);
            end
            if (x.we && (ldata !== x.ldata || lidx !== 5'd31)) begin
               n_bad++;
               $display("FAIL %s link actual %h/%0d expected %h/31", x.req, ldata, lidx, x.ldata);
            end
         end
      end
   end

   initial begin : watchdog
      #(20 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      kind = 3'd0; pc = '0; instr = '0; eq = 1'b0; jrv = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      drive("R1 idle", 3'd0, 32'h0, 32'h0, 1'b0, 32'h0);
      drive("R1", 3'd0, 32'h0040_1000, 32'h1234_5678, 1'b1, 32'h0);
      drive("R1 wrap", 3'd0, 32'hFFFF_FFFC, 32'h0, 1'b0, 32'h0);
      drive("R2", 3'd1, 32'h0040_0000, 32'h1085_0010, 1'b1, 32'h0);
      drive("R3", 3'd1, 32'h0040_0000, 32'h1085_0010, 1'b0, 32'h0);
      drive("R4 taken", 3'd2, 32'h0040_0100, 32'h1485_0020, 1'b0, 32'h0);
      drive("R4 fall", 3'd2, 32'h0040_0100, 32'h1485_0020, 1'b1, 32'h0);
      drive("R5 self", 3'd1, 32'h0040_0200, 32'h1000_FFFF, 1'b1, 32'h0);
      drive("R5 far", 3'd2, 32'h0040_0200, 32'h1400_8000, 1'b0, 32'h0);
      drive("R6", 3'd3, 32'h1234_5678, 32'h0BFF_FFFF, 1'b0, 32'h0);
      drive("R7", 3'd4, 32'h8000_0010, 32'h0C00_2710, 1'b0, 32'h0);
      drive("R8", 3'd5, 32'h0040_0000, 32'h03E0_0008, 1'b0, 32'hDEAD_BEEF);
      drive("R9 jmp", 3'd3, 32'h0, 32'h0800_0001, 1'b1, 32'h0);
      drive("R9 jreg", 3'd5, 32'h0, 32'h0, 1'b1, 32'h1111_1110);
      drive("R10 six", 3'd6, 32'h0000_0FF0, 32'hFFFF_FFFF, 1'b1, 32'h5555_5555);
      drive("R10 seven", 3'd7, 32'h0000_0FF0, 32'hFFFF_FFFF, 1'b0, 32'h5555_5555);
      drive("R11 jmp", 3'd3, 32'h0FFF_FFFC, 32'h0800_0004, 1'b0, 32'h0);
      drive("R11 jal", 3'd4, 32'hEFFF_FFFC, 32'h0C00_0040, 1'b0, 32'h0);
      for (int i = 0; i < 400; i++) begin
         logic [2:0] k = 3'($urandom_range(0, 7));
         drive("R9 random", k, $urandom, $urandom, 1'($urandom), $urandom);
      end
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule